// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits in the dispatch stage of an in-order, two-pipe integer core. One shared instruction buffer feeds both pipes. Each cycle the block looks at the two oldest entries of that buffer, called the head and the follower. The head always goes to the primary pipe when it can issue. The follower may issue at the same time into the secondary pipe. This happens only when it is allowed to run there and does not conflict with the head.

The decision is purely combinational and is made in the same cycle. The buffer uses the pop count to retire 0, 1 or 2 entries. A follower that cannot pair stays in the buffer. It becomes the head on the next cycle and then goes to the primary pipe. Issue is deliberately unbalanced: the secondary pipe is used opportunistically. The core does not reorder instructions and does not rename registers.

Each entry carries a valid bit, a 3-bit class code, a 16-bit destination mask and a 16-bit source mask. Mask bits 0..7 are data registers and bits 8..15 are address registers. The head also carries a predicted-taken flag.

Top module: `pair_dispatch`

## Requirements
- R1: With stall low and the head valid, issue_pri is 1 in the same cycle.
- R2: issue_sec is never 1 without issue_pri. An invalid head issues nothing, whatever the follower holds.
- R3: The follower does not pair when the head's destination mask AND the follower's source mask is nonzero (read-after-write).
- R4: The follower does not pair when the two destination masks overlap (write-after-write).
- R5: A follower of class 3 (floating point) never issues into the secondary pipe.
- R6: Only follower classes 0 (simple ALU), 1 (load/store) and 2 (branch) are secondary-eligible. Classes 4 to 7 are locked to the primary pipe.
- R7: A head of class 2 with the predicted-taken flag set blocks pairing. The flag has no effect on any other head class.
- R8: When fewer than two entries are valid, at most one instruction issues.
- R9: With stall high, neither strobe is 1 and the pop count is 0.
- R10: pop_cnt always equals the number of strobes raised: 0, 1 or 2.
- R11: A follower whose destination overlaps only the head's sources (write-after-read) still pairs when all other rules allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| stall | input | 1 | Downstream hold; nothing issues while high |
| s0_valid | input | 1 | Head entry valid |
| s0_cls | input | 3 | Head class code |
| s0_taken | input | 1 | Head predicted taken (meaningful for class 2) |
| s0_dst | input | 16 | Head destination register mask |
| s0_src | input | 16 | Head source register mask |
| s1_valid | input | 1 | Follower entry valid |
| s1_cls | input | 3 | Follower class code |
| s1_dst | input | 16 | Follower destination register mask |
| s1_src | input | 16 | Follower source register mask |
| issue_pri | output | 1 | Head issues to primary pipe |
| issue_sec | output | 1 | Follower issues to secondary pipe |
| pop_cnt | output | 2 | Entries retired from the buffer |

## Verification
Directed pairs separate each blocking cause on its own. These are a read-after-write overlap, a write-after-write overlap, a floating-point or locked follower, and a taken branch head. Each uses otherwise independent masks, so a wrong rule shows up as a single changed strobe. A write-after-read pair and a taken flag on a non-branch head show that harmless cases still pair. Random entries with sparse one- and two-bit masks, mixed classes and occasional stalls or invalid slots give a steady mix of 0-, 1- and 2-wide issue. Every case is compared against a bench model of the rules.

// File: rtl/pair_dispatch.sv
module pair_dispatch #(
  parameter int NREG   = 16,
  parameter int CLS_W  = 3,
  parameter int FP_CLS = 3,
  parameter int BR_CLS = 2,
  parameter logic [(1<<CLS_W)-1:0] SEC_OK = 8'b0000_0111
) (
  input  logic             stall,
  input  logic             s0_valid,
  input  logic [CLS_W-1:0] s0_cls,
  input  logic             s0_taken,
  input  logic [NREG-1:0]  s0_dst,
  input  logic [NREG-1:0]  s0_src,
  input  logic             s1_valid,
  input  logic [CLS_W-1:0] s1_cls,
  input  logic [NREG-1:0]  s1_dst,
  input  logic [NREG-1:0]  s1_src,
  output logic             issue_pri,
  output logic             issue_sec,
  output logic [1:0]       pop_cnt
);

  logic raw_hit, waw_hit, sec_elig, head_redirect, pair_ok;

  assign raw_hit       = |(s0_dst & s1_src);
  assign waw_hit       = |(s0_dst & s1_dst);
  assign sec_elig      = SEC_OK[s1_cls] && (s1_cls != CLS_W'(FP_CLS));
  assign head_redirect = s0_taken && (s0_cls == CLS_W'(BR_CLS));
  assign pair_ok       = s1_valid && sec_elig && !raw_hit && !waw_hit && !head_redirect;

  assign issue_pri = !stall && s0_valid;
  assign issue_sec = issue_pri && pair_ok;

  always_comb begin
    if (stall || !s0_valid) pop_cnt = 2'd0;
    else if (pair_ok)       pop_cnt = 2'd2;
    else                    pop_cnt = 2'd1;
  end

  always_comb begin
    p_sec_implies_pri_r2: assert (!issue_sec || issue_pri)
      else $error("secondary issued without primary");
    p_raw_block_r3: assert (!(issue_sec && |(s0_dst & s1_src)))
      else $error("paired across RAW dependency");
    p_waw_block_r4: assert (!(issue_sec && |(s0_dst & s1_dst)))
      else $error("paired across WAW conflict");
    p_fp_primary_r5: assert (!(issue_sec && s1_cls == CLS_W'(FP_CLS)))
      else $error("floating point in secondary pipe");
    p_taken_block_r7: assert (!(issue_sec && s0_taken && s0_cls == CLS_W'(BR_CLS)))
      else $error("paired behind taken branch");
    p_single_valid_r8: assert (!(issue_sec && !s1_valid))
      else $error("issued invalid follower");
    p_stall_quiet_r9: assert (!(stall && (issue_pri || issue_sec)))
      else $error("issued under stall");
    p_pop_match_r10: assert (pop_cnt == {1'b0, issue_pri} + {1'b0, issue_sec})
      else $error("pop count mismatch");
  end

endmodule

// File: tb/sim_pair_dispatch.sv
module sim_pair_dispatch;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic stall, s0_valid, s0_taken, s1_valid;
  logic [2:0] s0_cls, s1_cls;
  logic [15:0] s0_dst, s0_src, s1_dst, s1_src;
  logic issue_pri, issue_sec;
  logic [1:0] pop_cnt;

  int total = 0;
  int bad = 0;

  pair_dispatch u0 (
    .stall(stall), .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_taken(s0_taken),
    .s0_dst(s0_dst), .s0_src(s0_src), .s1_valid(s1_valid), .s1_cls(s1_cls),
    .s1_dst(s1_dst), .s1_src(s1_src),
    .issue_pri(issue_pri), .issue_sec(issue_sec), .pop_cnt(pop_cnt)
  );

  function automatic logic [3:0] model();
    logic p, s;
    p = !stall && s0_valid;
    s = p && s1_valid && (s1_cls <= 3'd2)
        && ((s0_dst & s1_src) == 16'd0) && ((s0_dst & s1_dst) == 16'd0)
        && !(s0_taken && s0_cls == 3'd2);
    return {p, s, 2'(p) + 2'(s)};
  endfunction

  task automatic apply(input logic st, v0, input logic [2:0] c0, input logic tk,
                       input logic [15:0] d0, r0, input logic v1, input logic [2:0] c1,
                       input logic [15:0] d1, r1);
    @(negedge clk);
    stall = st; s0_valid = v0; s0_cls = c0; s0_taken = tk; s0_dst = d0; s0_src = r0;
    s1_valid = v1; s1_cls = c1; s1_dst = d1; s1_src = r1;
    #5;
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {issue_pri, issue_sec, pop_cnt};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s pri/sec/pop act=%b exp=%b", tag, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // idle: all invalid, nothing issues (R2, R8)
    apply(0,0,0,0,0,0, 0,0,0,0);              chk("R2 idle", 4'b0000);
    // independent simple pair (R1, R10)
    apply(0,1,0,0,16'h0001,16'h0002, 1,0,16'h0004,16'h0008); chk("R1 R10 pair", 4'b1110);
    // head invalid, follower valid: nothing (R2)
    apply(0,0,0,0,16'h0001,0, 1,0,16'h0004,0); chk("R2 head invalid", 4'b0000);
    // only head valid (R8)
    apply(0,1,0,0,16'h0001,0, 0,0,16'h0004,0); chk("R8 single", 4'b1001);
    // RAW on address reg bit 9 (R3)
    apply(0,1,1,0,16'h0200,0, 1,0,16'h0001,16'h0200); chk("R3 raw", 4'b1001);
    // WAW (R4)
    apply(0,1,0,0,16'h0010,0, 1,1,16'h0010,16'h0001); chk("R4 waw", 4'b1001);
    // WAR allowed (R11)
    apply(0,1,0,0,16'h0001,16'h0080, 1,0,16'h0080,16'h0002); chk("R11 war", 4'b1110);
    // FP follower (R5)
    apply(0,1,0,0,16'h0001,0, 1,3,16'h0002,16'h0004); chk("R5 fp", 4'b1001);
    // locked classes 4..7 and eligible 0..2 (R6)
    for (int c = 0; c < 8; c++) begin
      apply(0,1,0,0,16'h0001,0, 1,3'(c),16'h0002,16'h0004);
      chk("R6 class", (c <= 2) ? 4'b1110 : 4'b1001);
    end
    // taken branch head blocks; taken flag on non-branch ignored (R7)
    apply(0,1,2,1,0,16'h0001, 1,0,16'h0002,16'h0004); chk("R7 taken br", 4'b1001);
    apply(0,1,2,0,0,16'h0001, 1,0,16'h0002,16'h0004); chk("R7 not taken br", 4'b1110);
    apply(0,1,0,1,16'h0001,0, 1,0,16'h0002,16'h0004); chk("R7 flag ignored", 4'b1110);
    // stall (R9)
    apply(1,1,0,0,16'h0001,0, 1,0,16'h0002,16'h0004); chk("R9 stall", 4'b0000);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d0, r0, d1, r1;
      d0 = 16'(1) << ($urandom % 16);
      r0 = (16'(1) << ($urandom % 16)) | (16'(1) << ($urandom % 16));
      d1 = 16'(1) << ($urandom % 16);
      r1 = (16'(1) << ($urandom % 16)) | (16'(1) << ($urandom % 16));
      apply(($urandom % 8) == 0, ($urandom % 8) != 0, 3'($urandom % 8), ($urandom % 4) == 0,
            d0, r0, ($urandom % 8) != 0, 3'($urandom % 8), d1, r1);
      chk("R1-model R3 R4 R5 R6 R7 R9 R10 random", model());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule